// File: doc/BRIEF.md
# Reset and Low-Power Mode Controller

This block sits beside the core of a small 8-bit microcontroller. It turns the oscillator clock into the core's clock enables, and it qualifies the external reset pin. It also holds the two sleep-request flags that software writes, and it runs the state machine that moves the core between normal running, idle and power-down. The core, the peripherals and the pin drivers use its level outputs to decide whether they are clocked, whether the oscillator should run, and which level the two bus strobes take while the core sleeps.

The oscillator period is the base unit. A divide-by-two stage makes the core clock enable, so the duty cycle of the input clock has no effect, and a machine cycle spans twelve oscillator periods. The reset pin is first synchronised. It becomes an internal reset only after it has stayed high for two full machine cycles while the oscillator runs.

Idle stops only the CPU clock and wakes on any enabled interrupt. Power-down also stops the oscillator and wakes only through the reset pin. A high reset pin restarts the oscillator so that the qualification count can run.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `osc_en` is high, `core_ce` is high on exactly every second oscillator cycle and is never high on two cycles in a row, giving 12 pulses in 24 cycles.
- R2: While the oscillator runs, `mcycle_end` pulses once every 12 oscillator cycles, giving 2 pulses in 24 cycles.
- R3: `core_rst` rises only after `reset_pin` has been high for 24 consecutive cycles. A 23-cycle pulse causes no reset. A low cycle restarts the count, so two 20-cycle pulses separated by one low cycle cause no reset.
- R4: A qualified reset returns the mode to running and clears both flags. `core_rst` falls within 3 cycles after `reset_pin` goes low.
- R5: A write (`sfr_wr`) loads `idle_flag` and `pdown_flag`. The mode changes only on the `insn_end` pulse that follows, one cycle later at the outputs. If both flags are set, power-down wins.
- R6: In idle, `cpu_gate`=0, `periph_gate`=1 and `osc_en`=1, with `strobe_hold`=1 and `strobe_lvl`=1 (strobes forced high).
- R7: In idle, any bit with both `irq_pend` and `irq_en` set returns the mode to running on the next cycle and clears `idle_flag`. A pending interrupt whose enable is 0 leaves the core in idle.
- R8: In power-down, `osc_en`=0, `cpu_gate`=0, `periph_gate`=0, `core_ce` stays 0, `strobe_hold`=1 and `strobe_lvl`=0 (strobes forced low). No interrupt ends power-down.
- R9: In power-down, a high `reset_pin` raises `osc_en` again. Holding the pin long enough then gives a reset that ends power-down.
- R10: While the block reset `rst` is high, `core_rst`=1, the mode is running and both flags are 0. `insn_end` outside running mode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high power-on reset of the block |
| reset_pin | input | 1 | External reset pin, asynchronous |
| sfr_wr | input | 1 | Write strobe for the power-control flags |
| sfr_idle | input | 1 | Idle request value written |
| sfr_pdown | input | 1 | Power-down request value written |
| insn_end | input | 1 | Pulse when the current instruction completes |
| irq_pend | input | N_IRQ | Interrupt pending bits |
| irq_en | input | N_IRQ | Interrupt enable bits |
| core_ce | output | 1 | Divided core clock enable |
| mcycle_end | output | 1 | Pulse at the end of each machine cycle |
| cpu_gate | output | 1 | CPU clock allowed |
| periph_gate | output | 1 | Peripheral clock allowed |
| osc_en | output | 1 | Oscillator enable |
| core_rst | output | 1 | Qualified internal reset |
| strobe_hold | output | 1 | Bus strobes forced to a fixed level |
| strobe_lvl | output | 1 | Level of the forced strobes |
| idle_flag | output | 1 | Idle request flag |
| pdown_flag | output | 1 | Power-down request flag |

## Verification
A wrong mode state shows on the very next cycle as a mismatched combination of `cpu_gate`, `periph_gate`, `osc_en` and the strobe levels. The bench therefore compares these outputs against a reference model one cycle after every random write, instruction end or interrupt. A wrong qualification count shows only at the end of a reset pulse, so directed pulses of 23, 24 and two interrupted lengths decide it within about 30 cycles. A divider that is stuck or doubled shows within 24 cycles in the pulse counts of `core_ce` and `mcycle_end`.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_PDOWN = 2'd2
  } pm_mode_t;
endpackage

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
  parameter int HOLD_CYC = 24,
  parameter int SYNC_STG = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  input  logic osc_run,
  output logic pin_sync,
  output logic rst_out
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic [SYNC_STG-1:0] sync_q;
  logic [CW-1:0]       cnt_q;
  logic                rst_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STG-2:0], pin_async};
  end

  assign pin_sync = sync_q[SYNC_STG-1];

  // count consecutive high samples; a low sample restarts the count
  always_ff @(posedge clk) begin
    if (rst || !pin_sync)
      cnt_q <= '0;
    else if (osc_run && (cnt_q < CW'(HOLD_CYC - 1)))
      cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rst_q <= 1'b1;
    else
      rst_q <= pin_sync && (rst_q || (osc_run && (cnt_q == CW'(HOLD_CYC - 1))));
  end

  assign rst_out = rst_q;
endmodule

// File: rtl/pmc_clk_div.sv
module pmc_clk_div #(
  parameter int OSC_PER_MC = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_run,
  output logic core_ce,
  output logic mcycle_end
);
  localparam int CE_PER_MC = OSC_PER_MC / 2;
  localparam int MW        = (CE_PER_MC > 1) ? $clog2(CE_PER_MC) : 1;

  logic          phase_q;
  logic          ce_q;
  logic          mc_q;
  logic [MW-1:0] slot_q;
  logic          ce_d;

  assign ce_d = osc_run && phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      ce_q    <= 1'b0;
      mc_q    <= 1'b0;
      slot_q  <= '0;
    end else begin
      if (osc_run) phase_q <= ~phase_q;
      ce_q <= ce_d;
      mc_q <= ce_d && (slot_q == MW'(CE_PER_MC - 1));
      if (ce_d) slot_q <= (slot_q == MW'(CE_PER_MC - 1)) ? '0 : slot_q + 1'b1;
    end
  end

  assign core_ce    = ce_q;
  assign mcycle_end = mc_q;
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
#(
  parameter int N_IRQ = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             core_rst,
  input  logic             pin_sync,
  input  logic             sfr_wr,
  input  logic             sfr_idle,
  input  logic             sfr_pdown,
  input  logic             insn_end,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  output logic             cpu_gate,
  output logic             periph_gate,
  output logic             osc_en,
  output logic             strobe_hold,
  output logic             strobe_lvl,
  output logic             idle_flag,
  output logic             pdown_flag
);
  pm_mode_t mode_q, mode_d;
  logic     idle_q, idle_d, pd_q, pd_d;
  logic     wake;

  assign wake = |(irq_pend & irq_en);

  always_comb begin
    mode_d = mode_q;
    idle_d = idle_q;
    pd_d   = pd_q;
    if (sfr_wr) begin
      idle_d = sfr_idle;
      pd_d   = sfr_pdown;
    end
    unique case (mode_q)
      PM_RUN: begin
        if (insn_end && pd_q)        mode_d = PM_PDOWN;
        else if (insn_end && idle_q) mode_d = PM_IDLE;
      end
      PM_IDLE: begin
        if (wake) begin
          mode_d = PM_RUN;
          idle_d = 1'b0;
        end
      end
      PM_PDOWN: mode_d = PM_PDOWN;
      default:  mode_d = PM_RUN;
    endcase
    if (core_rst) begin
      mode_d = PM_RUN;
      idle_d = 1'b0;
      pd_d   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= PM_RUN;
      idle_q      <= 1'b0;
      pd_q        <= 1'b0;
      cpu_gate    <= 1'b1;
      periph_gate <= 1'b1;
      osc_en      <= 1'b1;
      strobe_hold <= 1'b0;
      strobe_lvl  <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      idle_q      <= idle_d;
      pd_q        <= pd_d;
      cpu_gate    <= (mode_d == PM_RUN);
      periph_gate <= (mode_d != PM_PDOWN);
      osc_en      <= (mode_d != PM_PDOWN) || pin_sync;
      strobe_hold <= (mode_d != PM_RUN);
      strobe_lvl  <= (mode_d == PM_IDLE);
    end
  end

  assign idle_flag  = idle_q;
  assign pdown_flag = pd_q;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int N_IRQ      = 4,
  parameter int OSC_PER_MC = 12,
  parameter int RST_MC     = 2,
  parameter int SYNC_STG   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reset_pin,
  input  logic             sfr_wr,
  input  logic             sfr_idle,
  input  logic             sfr_pdown,
  input  logic             insn_end,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  output logic             core_ce,
  output logic             mcycle_end,
  output logic             cpu_gate,
  output logic             periph_gate,
  output logic             osc_en,
  output logic             core_rst,
  output logic             strobe_hold,
  output logic             strobe_lvl,
  output logic             idle_flag,
  output logic             pdown_flag
);
  localparam int HOLD_CYC = OSC_PER_MC * RST_MC;

  logic pin_sync;

  pmc_rst_qual #(.HOLD_CYC(HOLD_CYC), .SYNC_STG(SYNC_STG)) u_qual (
    .clk(clk), .rst(rst), .pin_async(reset_pin), .osc_run(osc_en),
    .pin_sync(pin_sync), .rst_out(core_rst)
  );

  pmc_clk_div #(.OSC_PER_MC(OSC_PER_MC)) u_div (
    .clk(clk), .rst(rst), .osc_run(osc_en),
    .core_ce(core_ce), .mcycle_end(mcycle_end)
  );

  pmc_mode_fsm #(.N_IRQ(N_IRQ)) u_fsm (
    .clk(clk), .rst(rst), .core_rst(core_rst), .pin_sync(pin_sync),
    .sfr_wr(sfr_wr), .sfr_idle(sfr_idle), .sfr_pdown(sfr_pdown),
    .insn_end(insn_end), .irq_pend(irq_pend), .irq_en(irq_en),
    .cpu_gate(cpu_gate), .periph_gate(periph_gate), .osc_en(osc_en),
    .strobe_hold(strobe_hold), .strobe_lvl(strobe_lvl),
    .idle_flag(idle_flag), .pdown_flag(pdown_flag)
  );
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int N_IRQ = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             reset_pin,
  input logic [N_IRQ-1:0] irq_pend,
  input logic [N_IRQ-1:0] irq_en,
  input logic             core_ce,
  input logic             cpu_gate,
  input logic             periph_gate,
  input logic             osc_en,
  input logic             core_rst,
  input logic             strobe_hold,
  input logic             strobe_lvl,
  input logic             idle_flag,
  input logic             pdown_flag
);
  a_r1_ce_alternates: assert property (@(posedge clk) disable iff (rst)
    core_ce |=> !core_ce);

  a_r8_no_ce_when_osc_off: assert property (@(posedge clk) disable iff (rst)
    !osc_en |=> !core_ce);

  a_r6_idle_strobes_high: assert property (@(posedge clk) disable iff (rst)
    (!cpu_gate && periph_gate) |-> (strobe_hold && strobe_lvl && osc_en));

  a_r8_pdown_strobes_low: assert property (@(posedge clk) disable iff (rst)
    !periph_gate |-> (strobe_hold && !strobe_lvl && !cpu_gate));

  a_r4_rst_clears_flags: assert property (@(posedge clk) disable iff (rst)
    core_rst |=> (!idle_flag && !pdown_flag));

  a_r7_idle_wake: assert property (@(posedge clk) disable iff (rst)
    (!cpu_gate && periph_gate && (|(irq_pend & irq_en))) |=> cpu_gate);

  a_r8_irq_no_pdown_wake: assert property (@(posedge clk) disable iff (rst)
    (!periph_gate && !core_rst) |=> !cpu_gate);

  a_r3_rst_needs_pin: assert property (@(posedge clk) disable iff (rst)
    $rose(core_rst) |-> $past(reset_pin, 3));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk(clk), .rst(rst), .reset_pin(reset_pin), .irq_pend(irq_pend),
  .irq_en(irq_en), .core_ce(core_ce), .cpu_gate(cpu_gate),
  .periph_gate(periph_gate), .osc_en(osc_en), .core_rst(core_rst),
  .strobe_hold(strobe_hold), .strobe_lvl(strobe_lvl),
  .idle_flag(idle_flag), .pdown_flag(pdown_flag)
);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;
  localparam int NI = 4;
  localparam int M_RUN = 0, M_IDLE = 1, M_PD = 2;

  logic clk = 0, rst = 1, reset_pin = 0;
  logic sfr_wr = 0, sfr_idle = 0, sfr_pdown = 0, insn_end = 0;
  logic [NI-1:0] irq_pend = '0, irq_en = '0;
  logic core_ce, mcycle_end, cpu_gate, periph_gate, osc_en, core_rst;
  logic strobe_hold, strobe_lvl, idle_flag, pdown_flag;

  int checks = 0, errors = 0;
  int m_mode = M_RUN;
  bit m_idle = 0, m_pd = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.N_IRQ(NI)) u_dut (
    .clk(clk), .rst(rst), .reset_pin(reset_pin), .sfr_wr(sfr_wr),
    .sfr_idle(sfr_idle), .sfr_pdown(sfr_pdown), .insn_end(insn_end),
    .irq_pend(irq_pend), .irq_en(irq_en), .core_ce(core_ce),
    .mcycle_end(mcycle_end), .cpu_gate(cpu_gate), .periph_gate(periph_gate),
    .osc_en(osc_en), .core_rst(core_rst), .strobe_hold(strobe_hold),
    .strobe_lvl(strobe_lvl), .idle_flag(idle_flag), .pdown_flag(pdown_flag)
  );

  function automatic logic [6:0] exp_outs(int mode, bit fi, bit fp);
    return {mode == M_RUN, mode != M_PD, mode != M_PD,
            mode != M_RUN, mode == M_IDLE, fi, fp};
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [6:0] outs();
    return {cpu_gate, periph_gate, osc_en, strobe_hold, strobe_lvl, idle_flag, pdown_flag};
  endfunction

  task automatic chk_model(input string req);
    chk(32'(outs()), 32'(exp_outs(m_mode, m_idle, m_pd)), req);
  endtask

  // one cycle of stimulus, sampled at the next falling edge
  task automatic do_write(input bit fi, input bit fp);
    sfr_wr = 1; sfr_idle = fi; sfr_pdown = fp;
    @(negedge clk);
    sfr_wr = 0;
    m_idle = fi; m_pd = fp;
  endtask

  task automatic do_insn();
    insn_end = 1;
    @(negedge clk);
    insn_end = 0;
    if (m_mode == M_RUN) begin
      if (m_pd) m_mode = M_PD;
      else if (m_idle) m_mode = M_IDLE;
    end
  endtask

  task automatic do_irq(input logic [NI-1:0] p, input logic [NI-1:0] e);
    irq_pend = p; irq_en = e;
    @(negedge clk);
    irq_pend = '0; irq_en = '0;
    if (m_mode == M_IDLE && |(p & e)) begin
      m_mode = M_RUN; m_idle = 0;
    end
  endtask

  task automatic pin_pulse(input int n, output bit seen);
    seen = 0;
    reset_pin = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (core_rst) seen = 1;
    end
    reset_pin = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (core_rst) seen = 1;
    end
  endtask

  task automatic model_reset();
    m_mode = M_RUN; m_idle = 0; m_pd = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seen;
    int ce_n, mc_n, fall_at;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(32'(core_rst), 1, "R10 core_rst during rst");
    chk_model("R10 state during rst");
    rst = 0;
    repeat (4) @(negedge clk);
    chk(32'(core_rst), 0, "R10 core_rst released");

    // R1 / R2 divider counts
    ce_n = 0; mc_n = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      ce_n += int'(core_ce); mc_n += int'(mcycle_end);
    end
    chk(32'(ce_n), 12, "R1 core_ce per 24");
    chk(32'(mc_n), 2, "R2 mcycle_end per 24");

    // R3 qualification
    pin_pulse(23, seen);
    chk(32'(seen), 0, "R3 23-cycle pulse");
    reset_pin = 1; repeat (20) @(negedge clk);
    reset_pin = 0; @(negedge clk);
    pin_pulse(20, seen);
    chk(32'(seen), 0, "R3 count restarts");
    // R4 reset clears flags and mode, releases promptly
    do_write(1, 0); do_insn();
    chk_model("R6 idle entry");
    reset_pin = 1; seen = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (core_rst) seen = 1;
    end
    @(negedge clk); @(negedge clk);
    chk(32'(core_rst), 1, "R3 24-cycle pulse resets");
    reset_pin = 0;
    fall_at = 99;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (!core_rst && fall_at == 99) fall_at = i;
    end
    chk(32'(fall_at <= 3), 1, "R4 release delay");
    model_reset();
    chk_model("R4 run and flags cleared");

    // R5 priority
    do_write(1, 1);
    chk_model("R5 flags loaded");
    chk(32'(cpu_gate), 1, "R5 no entry before insn_end");
    do_insn();
    chk_model("R5 pdown priority");
    // R8 pdown
    chk(32'({osc_en, strobe_hold, strobe_lvl}), 32'b010, "R8 pdown levels");
    do_irq('1, '1);
    chk_model("R8 irq no wake");
    ce_n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); ce_n += int'(core_ce);
    end
    chk(32'(ce_n), 0, "R8 core_ce stopped");
    // R9 pin restarts oscillator then resets
    reset_pin = 1;
    repeat (4) @(negedge clk);
    chk(32'(osc_en), 1, "R9 osc_en back");
    repeat (30) @(negedge clk);
    chk(32'(core_rst), 1, "R9 reset from pdown");
    reset_pin = 0;
    repeat (5) @(negedge clk);
    model_reset();
    chk_model("R9 running after reset");

    // R7 idle wake with and without enable
    do_write(1, 0); do_insn();
    do_irq(4'b0010, 4'b1101);
    chk_model("R7 disabled irq keeps idle");
    do_insn();
    chk_model("R10 insn_end in idle ignored");
    do_irq(4'b0100, 4'b0100);
    chk_model("R7 enabled irq wakes");
    chk(32'(idle_flag), 0, "R7 idle flag cleared");

    // random mix against the model (R5 R6 R7 R8)
    for (int n = 0; n < 300; n++) begin
      int op;
      op = int'($urandom_range(0, 3));
      if (m_mode == M_PD) begin
        reset_pin = 1; repeat (40) @(negedge clk);
        reset_pin = 0; repeat (5) @(negedge clk);
        model_reset();
        chk_model("R9 random pdown exit");
      end else begin
        case (op)
          0: do_write(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0));
          1: do_insn();
          default: do_irq(NI'($urandom), NI'($urandom));
        endcase
        chk_model("R5 R6 R7 random step");
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule